// File: doc/BRIEF.md
# Four-Channel Digital Potentiometer Two-Wire Register Controller

This block is the serial control logic of a four-channel digital potentiometer. It is an I2C slave. It watches the clock and data lines, which arrive already synchronised to the system clock. It answers when the device identifier matches and the three strap pins agree. It accepts one address byte and then either stores one data byte or returns one data byte. Four volatile wiper registers drive the 8-bit wiper outputs. Four non-volatile initial-value registers are modelled as an internal register array.

A write to a volatile wiper register takes effect as soon as the data byte is acknowledged. A write to an initial-value register is held as pending. The STOP that closes that transfer starts a timed storage cycle. While that cycle runs, `busy_o` is high and the controller ignores the bus, including START. After reset, `busy_o` is also high for a short power-up window, during which the bus is ignored in the same way.

The controller is one state machine with these states:
- IDLE: waiting for a START.
- DEV: shifting in the identifier.
- DEV_ACK: acknowledging the identifier.
- ADDR: shifting in the address.
- ADDR_ACK: acknowledging the address.
- WDATA: shifting in the write data.
- WDATA_ACK: acknowledging the write data.
- RDATA: shifting out the read data.
- RACK: the master's acknowledge slot.
- WAIT: SDA released until the next START or STOP.

Its transitions are:
- START enters DEV from any state.
- STOP enters IDLE from any state.
- `busy_o` high forces IDLE.
- DEV goes to DEV_ACK on a match, otherwise to WAIT.
- DEV_ACK goes to RDATA for a read, otherwise to ADDR.
- ADDR goes to ADDR_ACK for a mapped address, otherwise to WAIT.
- ADDR_ACK goes to WDATA.
- WDATA goes to WDATA_ACK.
- WDATA_ACK goes to WAIT.
- RDATA goes to RACK.
- RACK goes to WAIT.

Every byte transition happens on the SCL falling edge that follows the eighth or the ninth rising edge of that byte.

Top module: `dpot_i2c_ctrl`

## Requirements
- R1: Reset state. During and after reset, every wiper output reads 80h and SDA is not driven. `busy_o` stays high for `PU_CYC` clock cycles after reset is released.
- R2: Byte timing. A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. Bytes are taken most significant bit first. Bytes clocked in without a preceding START are never acknowledged.
- R3: Identifier. The identifier byte is matched as bits 7..4 = 1010, bits 3..1 = `strap_i[2:0]`, and bit 0 = direction (1 = read, 0 = write). A matching identifier is acknowledged by pulling SDA low on the ninth clock. A mismatch is not acknowledged, and SDA stays released until the next START.
- R4: Address map. Address bytes 00h..03h select wiper registers 0..3, and 08h..0Bh select initial-value registers 0..3. Both ranges are acknowledged. Every other address is not acknowledged.
- R5: Wiper write. After a write identifier and a wiper address, the data byte is acknowledged. It appears on `wiper_o[8*n+7:8*n]` once the acknowledge is given, and `busy_o` stays low.
- R6: Read. After a read identifier, the register last addressed is shifted out most significant bit first on eight SCL clocks. SDA is released during the ninth clock, where the master acknowledges.
- R7: Non-volatile write. A STOP that ends a write to an initial-value register raises `busy_o` for exactly `NVW_CYC` clock cycles. Once the cycle ends, a read of that register returns the new value.
- R8: Deaf while busy. While `busy_o` is high, START and all other bus activity are ignored and SDA is never driven.
- R9: No side effects. A write to an initial-value register leaves all wiper outputs unchanged. A second data byte in one write is not acknowledged and changes no register.
- R10: Line discipline. The SDA drive enable only changes while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | active-low asynchronous reset |
| scl_i | input | 1 | synchronised serial clock |
| sda_i | input | 1 | synchronised serial data line level |
| strap_i | input | 3 | address strap levels, compared with identifier bits 3..1 |
| sda_oe_o | output | 1 | pull SDA low when 1 (open drain) |
| wiper_o | output | 32 | four 8-bit wiper settings, channel n at bits 8n+7..8n |
| busy_o | output | 1 | power-up or storage cycle in progress |

## Verification
The line edges are registered once, and the state moves on the system clock that follows a detected SCL edge. The acknowledge drive, the first read bit and the wiper update therefore appear one system clock after the SCL fall that ends a byte. The bench samples SDA a quarter bit later, in the middle of the next SCL high phase, and checks the wiper outputs only after the ninth clock has ended. `busy_o` rises on the clock that detects STOP and lasts `NVW_CYC` clocks. A monitor counts busy cycles at falling clock edges and compares the run length once busy has dropped.

// File: rtl/dpot_pkg.sv
package dpot_pkg;
    typedef enum logic [3:0] {
        S_IDLE, S_DEV, S_DEV_ACK, S_ADDR, S_ADDR_ACK,
        S_WDATA, S_WDATA_ACK, S_RDATA, S_RACK, S_WAIT
    } fsm_e;

    localparam logic [3:0] ID_PREFIX = 4'b1010;
endpackage

// File: rtl/dpot_bus_mon.sv
module dpot_bus_mon (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    always_comb begin
        scl_rise  = scl_i & ~scl_q;
        scl_fall  = ~scl_i & scl_q;
        start_det = scl_i & scl_q & sda_q & ~sda_i;
        stop_det  = scl_i & scl_q & ~sda_q & sda_i;
    end
endmodule

// File: rtl/dpot_regs.sv
module dpot_regs #(
    parameter int             NCH      = 4,
    parameter int             DW       = 8,
    parameter int             NVW_CYC  = 200,
    parameter int             PU_CYC   = 16,
    parameter logic [DW-1:0]  INIT_VAL = 8'h80,
    localparam int            CW       = $clog2(NCH),
    localparam int            IW       = CW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2*NCH-1:0]  wr_sel,
    input  logic [DW-1:0]     wr_data,
    input  logic              stop_i,
    input  logic [IW-1:0]     rd_idx,
    output logic [DW-1:0]     rd_data,
    output logic [NCH*DW-1:0] wiper_o,
    output logic              busy_o
);
    localparam int TMAX = (NVW_CYC > PU_CYC) ? NVW_CYC : PU_CYC;
    localparam int TW   = $clog2(TMAX + 1);

    logic [DW-1:0] wreg  [NCH];
    logic [DW-1:0] nvreg [NCH];
    logic [TW-1:0] timer;
    logic          pend_vld;
    logic [CW-1:0] pend_idx, hit_idx;
    logic [DW-1:0] pend_dat;
    logic          nv_hit, commit;

    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < NCH; i++)
            if (wr_sel[NCH+i]) hit_idx = CW'(i);
    end
    assign nv_hit = |wr_sel[2*NCH-1:NCH];
    assign commit = (timer == TW'(1)) && pend_vld;
    assign busy_o = (timer != '0);

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         wreg[g] <= INIT_VAL;
            else if (wr_sel[g]) wreg[g] <= wr_data;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                nvreg[g] <= INIT_VAL;
            else if (commit && pend_idx == CW'(g))     nvreg[g] <= pend_dat;
        end
        assign wiper_o[g*DW +: DW] = wreg[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            timer    <= TW'(PU_CYC);
            pend_vld <= 1'b0;
            pend_idx <= '0;
            pend_dat <= '0;
        end else begin
            if (nv_hit) begin
                pend_vld <= 1'b1;
                pend_idx <= hit_idx;
                pend_dat <= wr_data;
            end else if (commit) begin
                pend_vld <= 1'b0;
            end
            if (stop_i && pend_vld && timer == '0) timer <= TW'(NVW_CYC);
            else if (timer != '0)                  timer <= timer - TW'(1);
        end
    end

    assign rd_data = rd_idx[IW-1] ? nvreg[rd_idx[CW-1:0]] : wreg[rd_idx[CW-1:0]];
endmodule

// File: rtl/dpot_i2c_ctrl.sv
module dpot_i2c_ctrl #(
    parameter int            NCH      = 4,
    parameter int            DW       = 8,
    parameter int            NV_BASE  = 8,
    parameter int            NVW_CYC  = 200,
    parameter int            PU_CYC   = 16,
    parameter logic [DW-1:0] INIT_VAL = 8'h80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [2:0]        strap_i,
    output logic              sda_oe_o,
    output logic [NCH*DW-1:0] wiper_o,
    output logic              busy_o
);
    import dpot_pkg::*;

    localparam int            CW    = $clog2(NCH);
    localparam int            IW    = CW + 1;
    localparam int            BCW   = $clog2(DW + 1);
    localparam logic [DW-1:0] NCH_V = DW'(NCH);
    localparam logic [DW-1:0] NVB_V = DW'(NV_BASE);

    fsm_e            st, st_nx;
    logic [BCW-1:0]  cnt;
    logic [DW-1:0]   shreg, tx, rd_data;
    logic [IW-1:0]   ptr, addr_idx;
    logic            rw, id_ok, addr_ok, byte_full, rx_st, wr_go;
    logic            scl_rise, scl_fall, start_det, stop_det;
    logic [2*NCH-1:0] wr_sel;

    dpot_bus_mon u_mon (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    dpot_regs #(
        .NCH(NCH), .DW(DW), .NVW_CYC(NVW_CYC), .PU_CYC(PU_CYC), .INIT_VAL(INIT_VAL)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_sel(wr_sel), .wr_data(shreg),
        .stop_i(stop_det), .rd_idx(ptr), .rd_data(rd_data),
        .wiper_o(wiper_o), .busy_o(busy_o)
    );

    assign byte_full = (cnt == BCW'(DW));
    assign id_ok     = (shreg[7:4] == ID_PREFIX) && (shreg[3:1] == strap_i);
    assign addr_ok   = (shreg < NCH_V) || (shreg >= NVB_V && shreg < NVB_V + NCH_V);
    assign addr_idx  = {shreg >= NVB_V, shreg[CW-1:0]};
    assign rx_st     = (st == S_DEV) || (st == S_ADDR) || (st == S_WDATA);
    assign wr_go     = (st == S_WDATA) && (st_nx == S_WDATA_ACK);

    for (genvar i = 0; i < 2*NCH; i++) begin : g_sel
        assign wr_sel[i] = wr_go && (ptr == IW'(i));
    end

    // next-state logic
    always_comb begin
        st_nx = st;
        if (busy_o)         st_nx = S_IDLE;
        else if (start_det) st_nx = S_DEV;
        else if (stop_det)  st_nx = S_IDLE;
        else if (scl_fall) begin
            unique case (st)
                S_DEV:       if (byte_full) st_nx = id_ok ? S_DEV_ACK : S_WAIT;
                S_DEV_ACK:   st_nx = rw ? S_RDATA : S_ADDR;
                S_ADDR:      if (byte_full) st_nx = addr_ok ? S_ADDR_ACK : S_WAIT;
                S_ADDR_ACK:  st_nx = S_WDATA;
                S_WDATA:     if (byte_full) st_nx = S_WDATA_ACK;
                S_WDATA_ACK: st_nx = S_WAIT;
                S_RDATA:     if (byte_full) st_nx = S_RACK;
                S_RACK:      st_nx = S_WAIT;
                default:     st_nx = st;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_nx;
    end

    // byte datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            shreg <= '0;
            tx    <= '0;
            ptr   <= '0;
            rw    <= 1'b0;
        end else begin
            if (start_det || st_nx != st)
                cnt <= '0;
            else if (scl_rise && (rx_st || st == S_RDATA) && !byte_full)
                cnt <= cnt + BCW'(1);
            if (scl_rise && rx_st)
                shreg <= {shreg[DW-2:0], sda_i};
            if (st == S_DEV && st_nx == S_DEV_ACK)
                rw <= shreg[0];
            if (st == S_ADDR && st_nx == S_ADDR_ACK)
                ptr <= addr_idx;
            if (st == S_DEV_ACK && st_nx == S_RDATA)
                tx <= rd_data;
            else if (st == S_RDATA && st_nx == S_RDATA && scl_fall && cnt != '0)
                tx <= {tx[DW-2:0], 1'b1};
        end
    end

    // outputs
    always_comb begin
        unique case (st)
            S_DEV_ACK, S_ADDR_ACK, S_WDATA_ACK: sda_oe_o = 1'b1;
            S_RDATA:                            sda_oe_o = ~tx[DW-1];
            default:                            sda_oe_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/dpot_i2c_chk.sv
module dpot_i2c_chk #(
    parameter int NCH     = 4,
    parameter int DW      = 8,
    parameter int NVW_CYC = 200
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_i,
    input logic              sda_oe_o,
    input logic              busy_o,
    input logic [NCH*DW-1:0] wiper_o,
    input logic [2*NCH-1:0]  wr_sel
);
    logic        busy_q, armed;
    int unsigned run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q <= 1'b1;
            armed  <= 1'b0;
            run    <= 0;
        end else begin
            busy_q <= busy_o;
            if (busy_o && !busy_q) begin
                armed <= 1'b1;
                run   <= 1;
            end else if (busy_o) begin
                run <= run + 1;
            end else if (busy_q) begin
                armed <= 1'b0;
            end
        end
    end

    // R8
    p_quiet_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !sda_oe_o);

    // R10
    p_oe_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_o) |-> !scl_i);

    // R5
    p_sel_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_sel));

    // R9
    p_wiper_hold_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(wiper_o));

    // R5
    p_wiper_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wiper_o) |-> $past(|wr_sel[NCH-1:0]));

    // R7
    p_nv_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !busy_o && armed) |-> (run == NVW_CYC));
endmodule

bind dpot_i2c_ctrl dpot_i2c_chk #(.NCH(NCH), .DW(DW), .NVW_CYC(NVW_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe_o(sda_oe_o),
    .busy_o(busy_o), .wiper_o(wiper_o), .wr_sel(wr_sel)
);

// File: tb/dpot_i2c_ctrl_test.sv
`timescale 1ns/1ps
module dpot_i2c_ctrl_test;
    localparam int NVW = 200;
    localparam int PU  = 16;
    localparam int Q   = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl = 1'b1;
    logic        sda_m = 1'b1;
    logic [2:0]  strap = 3'b101;
    logic        sda_oe, busy;
    logic [31:0] wiper;
    logic        sda_line;

    int checks = 0, errors = 0;
    int run_cnt = 0, last_run = 0, viol = 0;
    logic oe_prev = 1'b0;
    bit   done = 1'b0;
    logic [7:0] mdl [8];

    assign sda_line = sda_m & ~sda_oe;
    always #10 clk = ~clk;

    dpot_i2c_ctrl uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .strap_i(strap),
        .sda_oe_o(sda_oe), .wiper_o(wiper), .busy_o(busy)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (busy) run_cnt++;
            else begin
                if (run_cnt != 0) last_run = run_cnt;
                run_cnt = 0;
            end
            if (sda_oe != oe_prev && scl) viol++;
        end
        oe_prev = sda_oe;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; wq(Q); scl = 1'b1; wq(Q); sda_m = 1'b0; wq(Q); scl = 1'b0; wq(Q);
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; wq(Q); scl = 1'b1; wq(Q); sda_m = 1'b1; wq(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq(Q); scl = 1'b1; wq(2*Q); scl = 1'b0; wq(Q);
        end
        sda_m = 1'b1; wq(Q); scl = 1'b1; wq(Q);
        ack = (sda_line == 1'b0);
        wq(Q); scl = 1'b0; wq(Q);
    endtask

    task automatic recv_byte(output logic [7:0] b, output bit rel);
        b = '0;
        for (int i = 0; i < 8; i++) begin
            sda_m = 1'b1; wq(Q); scl = 1'b1; wq(Q);
            b = {b[6:0], sda_line};
            wq(Q); scl = 1'b0; wq(Q);
        end
        sda_m = 1'b0; wq(Q); scl = 1'b1; wq(Q);
        rel = (sda_oe == 1'b0);
        wq(Q); scl = 1'b0; wq(Q);
    endtask

    function automatic bit addr_ok(input logic [7:0] a);
        return (a < 8'd4) || (a >= 8'd8 && a < 8'd12);
    endfunction

    function automatic int addr_idx(input logic [7:0] a);
        return (a >= 8'd8) ? int'(a) - 4 : int'(a);
    endfunction

    function automatic logic [7:0] id_byte(input logic [2:0] s, input bit rd);
        return {4'b1010, s, rd};
    endfunction

    task automatic wait_idle();
        while (busy) @(negedge clk);
        wq(2);
    endtask

    task automatic check_wipers(input string tag);
        for (int c = 0; c < 4; c++)
            chk(wiper[c*8 +: 8] == mdl[c], tag, int'(wiper[c*8 +: 8]), int'(mdl[c]));
    endtask

    task automatic do_write(input logic [7:0] a, input logic [7:0] d);
        bit ack;
        i2c_start();
        send_byte(id_byte(strap, 1'b0), ack); chk(ack, "R3 id ack", ack, 1);
        send_byte(a, ack); chk(ack == addr_ok(a), "R4 addr ack", ack, addr_ok(a));
        if (addr_ok(a)) begin
            send_byte(d, ack); chk(ack, "R5 data ack", ack, 1);
            if (a < 8'd4) begin
                mdl[addr_idx(a)] = d;
                chk(busy == 1'b0, "R5 no busy", busy, 0);
            end
            check_wipers("R5 R9 wiper after write");
        end
        i2c_stop();
        if (addr_ok(a) && a >= 8'd8) begin
            wq(2);
            chk(busy == 1'b1, "R7 busy rises", busy, 1);
            wait_idle();
            chk(last_run == NVW, "R7 busy length", last_run, NVW);
            mdl[addr_idx(a)] = d;
        end
        wq(Q);
    endtask

    task automatic do_read(input logic [7:0] a);
        bit ack, rel;
        logic [7:0] v;
        i2c_start();
        send_byte(id_byte(strap, 1'b0), ack); chk(ack, "R3 id ack", ack, 1);
        send_byte(a, ack); chk(ack, "R4 addr ack", ack, 1);
        i2c_start();
        send_byte(id_byte(strap, 1'b1), ack); chk(ack, "R3 read id ack", ack, 1);
        recv_byte(v, rel);
        chk(v == mdl[addr_idx(a)], "R6 read data", int'(v), int'(mdl[addr_idx(a)]));
        chk(rel, "R6 release on ninth clock", rel, 1);
        i2c_stop();
        wq(Q);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        bit ack;
        int unsigned seed;
        int n;
        seed = $urandom(32'h5EED);
        for (int i = 0; i < 8; i++) mdl[i] = 8'h80;

        wq(5);
        chk(sda_oe == 1'b0, "R1 sda released in reset", sda_oe, 0);
        chk(busy == 1'b1, "R1 busy in reset", busy, 1);
        check_wipers("R1 reset wipers");
        rst_n = 1'b1;
        n = 0;
        while (busy) begin n++; @(negedge clk); end
        chk(n == PU, "R1 power-up busy length", n, PU);
        wq(4);

        // R2: byte without START
        scl = 1'b0; wq(Q);
        send_byte(id_byte(strap, 1'b0), ack);
        chk(!ack, "R2 no ack without start", ack, 0);
        i2c_stop(); wq(Q);

        // R3: mismatched strap, then SDA stays released
        i2c_start();
        send_byte(id_byte(3'b100, 1'b0), ack);
        chk(!ack, "R3 mismatch nack", ack, 0);
        send_byte(8'h00, ack);
        chk(!ack, "R3 released after mismatch", ack, 0);
        i2c_stop(); wq(Q);
        i2c_start();
        send_byte(8'hA0 ^ {4'b0000, strap, 1'b0} ^ 8'h80, ack);
        chk(!ack, "R3 wrong prefix nack", ack, 0);
        i2c_stop(); wq(Q);

        // R4: unmapped addresses
        do_write(8'h04, 8'h11);
        do_write(8'h0C, 8'h11);
        do_write(8'hFF, 8'h11);
        check_wipers("R4 unmapped writes no effect");

        // R5/R6: directed wiper writes and reads
        do_write(8'h02, 8'h00);
        do_write(8'h03, 8'hA5);
        do_read(8'h03);
        do_read(8'h02);

        // R9: second data byte refused
        i2c_start();
        send_byte(id_byte(strap, 1'b0), ack);
        send_byte(8'h01, ack);
        send_byte(8'h55, ack); chk(ack, "R5 first data ack", ack, 1);
        mdl[1] = 8'h55;
        send_byte(8'hAA, ack); chk(!ack, "R9 second byte nack", ack, 0);
        i2c_stop(); wq(Q);
        check_wipers("R9 second byte no effect");

        // R7/R8: non-volatile write, START during busy ignored
        i2c_start();
        send_byte(id_byte(strap, 1'b0), ack);
        send_byte(8'h08, ack);
        send_byte(8'h3C, ack); chk(ack, "R7 nv data ack", ack, 1);
        check_wipers("R9 wipers after nv write");
        i2c_stop();
        i2c_start();
        send_byte(id_byte(strap, 1'b1), ack);
        chk(!ack, "R8 start ignored while busy", ack, 0);
        chk(busy == 1'b1, "R8 still busy", busy, 1);
        wait_idle();
        chk(last_run == NVW, "R7 busy length", last_run, NVW);
        i2c_stop(); wq(Q);
        mdl[4] = 8'h3C;
        do_read(8'h08);
        do_read(8'h09);

        // random mix
        for (int t = 0; t < 30; t++) begin
            int op;
            logic [7:0] a, d;
            op = int'($urandom_range(0, 2));
            a  = ($urandom_range(0, 1) == 0) ? 8'($urandom_range(0, 3)) : 8'($urandom_range(8, 11));
            d  = 8'($urandom);
            if (op == 0)      do_write(a, d);
            else if (op == 1) do_read(a);
            else              do_write(8'($urandom_range(12, 255)), d);
        end
        check_wipers("R5 final wipers");
        chk(viol == 0, "R10 drive changes with SCL low", viol, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule